// File: doc/BRIEF.md
# Tag-Checked Register and Memory Datapath

This block is a datapath slice in which every 64-bit register and every 64-bit memory word carries a 2-bit type tag that software cannot address. The tag says what the word is: plain data, a data pointer, a code pointer, or protected data. Hardware carries the tag along on every move and checks it before a word is used as an address. Any use of a word as an address or as a branch target without the matching tag raises a fault instead of completing.

One operation is accepted per cycle. The operations are load, store, register move, add, indirect branch, and a tag-set operation that is meant for testing. Loads and stores take their word address from the low bits of a base register. That base must be tagged as a data pointer. An indirect branch must take its target from a register tagged as a code pointer. Results come out one cycle after the operation is issued, on registered outputs: a register write-back echo, a branch request, or a one-cycle fault pulse carrying a code that names the kind of violation. A faulting operation changes no register and no memory word.

Top module: `tagu_unit`

## Requirements
- R1: After reset, all outputs are 0, every register holds value 0 with tag 00, and every memory word's tag is 00.
- R2: A load (op_code 1) whose base register rs is tagged 01 writes register rd with both the value and the tag of memory word rs[MEM_AW-1:0]. The next cycle shows wb_valid=1 together with that value, tag and rd.
- R3: A load or store whose base register tag is not 01 raises fault with fault_code 01 in the next cycle. It does not change any register or memory word. This covers a base tagged 00, so plain data can never serve as a pointer.
- R4: A store (op_code 2) with base rs tagged 01 writes the value and the tag of register rt into memory word rs[MEM_AW-1:0], and gives wb_valid=0.
- R5: A move (op_code 3) copies both the value and the tag of rs into rd.
- R6: An add (op_code 4) writes rs+rt (modulo 2^64) into rd, with tag 00 whatever the operand tags.
- R7: An indirect branch (op_code 5) whose rs is tagged 10 gives br_valid=1 for one cycle, with br_target equal to the value of rs.
- R8: An indirect branch whose rs tag is not 10 raises fault with fault_code 10 and gives br_valid=0.
- R9: fault is a one-cycle pulse for each faulting operation. When fault is 0, fault_code is 00. A faulting cycle never shows wb_valid or br_valid.
- R10: A tag-set (op_code 6) writes imm into rd with tag set_tag. Tag encoding: 00 plain data, 01 data pointer, 10 code pointer, 11 protected data. op_code 0 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation select |
| rd | input | 3 | Destination register index |
| rs | input | 3 | Base / first source register index |
| rt | input | 3 | Second source register index |
| imm | input | 64 | Value written by tag-set |
| set_tag | input | 2 | Tag written by tag-set |
| wb_valid | output | 1 | A register was written by the previous operation |
| wb_reg | output | 3 | Index of the register written |
| wb_data | output | 64 | Value written |
| wb_tag | output | 2 | Tag written |
| br_valid | output | 1 | Indirect branch accepted |
| br_target | output | 64 | Branch target address |
| fault | output | 1 | One-cycle fault pulse |
| fault_code | output | 2 | 01 bad data base, 10 bad branch target |

## Verification
In a store, the base-tag check and the memory write fall in the same cycle. The check has to hold the write back in that same cycle rather than report the problem after the write has happened. The bench first places a known value and tag in a word. It then stores to that word through a base register that has lost its pointer tag, and reloads the word through a proper pointer to confirm that the old contents survived. It also stores a pointer register through itself (rs equal to rt), so the source tag and the base check read the same register in one cycle; the bench expects the reload to return the pointer value with tag 01.

// File: rtl/tagu_pkg.sv
package tagu_pkg;
  localparam int TAG_W = 2;

  typedef enum logic [1:0] {
    TAG_PLAIN = 2'b00,
    TAG_DPTR  = 2'b01,
    TAG_CPTR  = 2'b10,
    TAG_PROT  = 2'b11
  } tag_t;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_MOVE  = 3'd3,
    OP_ADD   = 3'd4,
    OP_JUMP  = 3'd5,
    OP_TSET  = 3'd6,
    OP_RSV   = 3'd7
  } op_t;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_BASE   = 2'b01,
    FLT_TARGET = 2'b10
  } flt_t;
endpackage

// File: rtl/tagu_regfile.sv
module tagu_regfile #(
  parameter int NREGS  = 8,
  parameter int DATA_W = 64,
  parameter int AW     = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [AW-1:0]             ra,
  output logic [DATA_W-1:0]         ra_val,
  output logic [tagu_pkg::TAG_W-1:0] ra_tag,
  input  logic [AW-1:0]             rb,
  output logic [DATA_W-1:0]         rb_val,
  output logic [tagu_pkg::TAG_W-1:0] rb_tag,
  input  logic                      we,
  input  logic [AW-1:0]             wa,
  input  logic [DATA_W-1:0]         wd,
  input  logic [tagu_pkg::TAG_W-1:0] wt
);
  logic [DATA_W-1:0]          val_q [NREGS];
  logic [tagu_pkg::TAG_W-1:0] tag_q [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) begin
        val_q[i] <= '0;
        tag_q[i] <= '0;
      end
    end else if (we) begin
      val_q[wa] <= wd;
      tag_q[wa] <= wt;
    end
  end

  assign ra_val = val_q[ra];
  assign ra_tag = tag_q[ra];
  assign rb_val = val_q[rb];
  assign rb_tag = tag_q[rb];
endmodule

// File: rtl/tagu_mem.sv
module tagu_mem #(
  parameter int WORDS  = 16,
  parameter int DATA_W = 64,
  parameter int AW     = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [AW-1:0]             addr,
  output logic [DATA_W-1:0]         rdata,
  output logic [tagu_pkg::TAG_W-1:0] rtag,
  input  logic                      we,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [tagu_pkg::TAG_W-1:0] wtag
);
  // Value array: no reset, single write port, distributed-RAM style read.
  logic [DATA_W-1:0]          data_q [WORDS];
  // Tag array: small, kept in flops so reset can clear it.
  logic [tagu_pkg::TAG_W-1:0] tag_q  [WORDS];

  always_ff @(posedge clk) begin
    if (we) data_q[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) tag_q[i] <= '0;
    end else if (we) begin
      tag_q[addr] <= wtag;
    end
  end

  assign rdata = data_q[addr];
  assign rtag  = tag_q[addr];
endmodule

// File: rtl/tagu_check.sv
module tagu_check
  import tagu_pkg::*;
(
  input  logic             op_valid,
  input  op_t              op,
  input  logic [TAG_W-1:0] base_tag,
  output flt_t             flt
);
  always_comb begin
    flt = FLT_NONE;
    if (op_valid) begin
      unique case (op)
        OP_LOAD, OP_STORE: if (base_tag != TAG_DPTR) flt = FLT_BASE;
        OP_JUMP:           if (base_tag != TAG_CPTR) flt = FLT_TARGET;
        default:           flt = FLT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/tagu_unit.sv
module tagu_unit
  import tagu_pkg::*;
#(
  parameter int NREGS     = 8,
  parameter int MEM_WORDS = 16,
  parameter int DATA_W    = 64,
  localparam int RAW = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int MAW = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [RAW-1:0]    rd,
  input  logic [RAW-1:0]    rs,
  input  logic [RAW-1:0]    rt,
  input  logic [DATA_W-1:0] imm,
  input  logic [TAG_W-1:0]  set_tag,
  output logic              wb_valid,
  output logic [RAW-1:0]    wb_reg,
  output logic [DATA_W-1:0] wb_data,
  output logic [TAG_W-1:0]  wb_tag,
  output logic              br_valid,
  output logic [DATA_W-1:0] br_target,
  output logic              fault,
  output logic [1:0]        fault_code
);
  op_t               op;
  flt_t              flt;
  logic [DATA_W-1:0] rs_val, rt_val, mem_rdata;
  logic [TAG_W-1:0]  rs_tag, rt_tag, mem_rtag;
  logic              rf_we, mem_we, br_go;
  logic [DATA_W-1:0] rf_wd;
  logic [TAG_W-1:0]  rf_wt;

  assign op = op_t'(op_code);

  tagu_regfile #(.NREGS(NREGS), .DATA_W(DATA_W), .AW(RAW)) u_rf (
    .clk(clk), .rst(rst),
    .ra(rs), .ra_val(rs_val), .ra_tag(rs_tag),
    .rb(rt), .rb_val(rt_val), .rb_tag(rt_tag),
    .we(rf_we), .wa(rd), .wd(rf_wd), .wt(rf_wt)
  );

  tagu_mem #(.WORDS(MEM_WORDS), .DATA_W(DATA_W), .AW(MAW)) u_mem (
    .clk(clk), .rst(rst),
    .addr(rs_val[MAW-1:0]), .rdata(mem_rdata), .rtag(mem_rtag),
    .we(mem_we), .wdata(rt_val), .wtag(rt_tag)
  );

  tagu_check u_chk (
    .op_valid(op_valid), .op(op), .base_tag(rs_tag), .flt(flt)
  );

  // Writes are enabled only when the tag check found nothing wrong.
  always_comb begin
    rf_we  = 1'b0;
    mem_we = 1'b0;
    br_go  = 1'b0;
    rf_wd  = rs_val;
    rf_wt  = rs_tag;
    if (op_valid && flt == FLT_NONE) begin
      unique case (op)
        OP_LOAD: begin rf_we = 1'b1; rf_wd = mem_rdata; rf_wt = mem_rtag; end
        OP_STORE: mem_we = 1'b1;
        OP_MOVE: rf_we = 1'b1;
        OP_ADD: begin rf_we = 1'b1; rf_wd = rs_val + rt_val; rf_wt = TAG_PLAIN; end
        OP_JUMP: br_go = 1'b1;
        OP_TSET: begin rf_we = 1'b1; rf_wd = imm; rf_wt = set_tag; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid   <= 1'b0;
      wb_reg     <= '0;
      wb_data    <= '0;
      wb_tag     <= '0;
      br_valid   <= 1'b0;
      br_target  <= '0;
      fault      <= 1'b0;
      fault_code <= FLT_NONE;
    end else begin
      wb_valid   <= rf_we;
      wb_reg     <= rf_we ? rd : '0;
      wb_data    <= rf_we ? rf_wd : '0;
      wb_tag     <= rf_we ? rf_wt : '0;
      br_valid   <= br_go;
      br_target  <= br_go ? rs_val : '0;
      fault      <= (flt != FLT_NONE);
      fault_code <= flt;
    end
  end

  // R3: a memory access through a base without the data-pointer tag faults.
  assert_base_fault_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op == OP_LOAD || op == OP_STORE) && rs_tag != TAG_DPTR)
    |=> (fault && fault_code == FLT_BASE && !wb_valid));

  // R2: a good load echoes the memory word's value and tag.
  assert_load_copy_R2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_LOAD && rs_tag == TAG_DPTR)
    |=> (wb_valid && wb_tag == $past(mem_rtag) && wb_data == $past(mem_rdata)));

  // R8: a branch from a non-code-pointer value faults and is not taken.
  assert_target_fault_R8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_JUMP && rs_tag != TAG_CPTR)
    |=> (fault && fault_code == FLT_TARGET && !br_valid));

  // R7: a branch from a code pointer is taken to that value.
  assert_branch_take_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_JUMP && rs_tag == TAG_CPTR)
    |=> (br_valid && br_target == $past(rs_val)));

  // R6: arithmetic results are plain data.
  assert_add_plain_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_ADD) |=> (wb_valid && wb_tag == TAG_PLAIN));

  // R9: a fault is exclusive with write-back and branch, and the code is zero otherwise.
  assert_fault_excl_R9: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!wb_valid && !br_valid && fault_code != FLT_NONE));
  assert_code_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !fault |-> (fault_code == FLT_NONE));
endmodule

// File: tb/tb_tagu_unit.sv
`timescale 1ns/1ps
module tb_tagu_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [2:0]  rd = '0, rs = '0, rt = '0;
  logic [63:0] imm = '0;
  logic [1:0]  set_tag = '0;
  logic        wb_valid, br_valid, fault;
  logic [2:0]  wb_reg;
  logic [63:0] wb_data, br_target;
  logic [1:0]  wb_tag, fault_code;

  int n_cmp = 0;
  int n_bad = 0;

  localparam logic [2:0] LD = 3'd1, ST = 3'd2, MV = 3'd3, AD = 3'd4, JP = 3'd5, TS = 3'd6;

  tagu_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .rd(rd), .rs(rs), .rt(rt), .imm(imm), .set_tag(set_tag),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data), .wb_tag(wb_tag),
    .br_valid(br_valid), .br_target(br_target),
    .fault(fault), .fault_code(fault_code)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one operation for one cycle; on return the registered results are visible.
  task automatic issue(input logic [2:0] oc, input logic [2:0] d, input logic [2:0] s,
                       input logic [2:0] t, input logic [63:0] v, input logic [1:0] tg);
    @(negedge clk);
    op_valid = 1'b1; op_code = oc; rd = d; rs = s; rt = t; imm = v; set_tag = tg;
    @(negedge clk);
    op_valid = 1'b0; op_code = '0;
  endtask

  task automatic nop();
    @(negedge clk);
  endtask

  task automatic expect_wb(input string req, input logic [2:0] r, input logic [63:0] v, input logic [1:0] tg);
    chk(req, "wb_valid", 64'(wb_valid), 64'd1);
    chk(req, "wb_reg", 64'(wb_reg), 64'(r));
    chk(req, "wb_data", wb_data, v);
    chk(req, "wb_tag", 64'(wb_tag), 64'(tg));
    chk(req, "fault", 64'(fault), 64'd0);
  endtask

  task automatic expect_fault(input string req, input logic [1:0] code);
    chk(req, "fault", 64'(fault), 64'd1);
    chk(req, "fault_code", 64'(fault_code), 64'(code));
    chk(req, "wb_valid", 64'(wb_valid), 64'd0);
    chk(req, "br_valid", 64'(br_valid), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1", "wb_valid", 64'(wb_valid), 64'd0);
    chk("R1", "br_valid", 64'(br_valid), 64'd0);
    chk("R1", "fault", 64'(fault), 64'd0);
    issue(MV, 3'd4, 3'd3, 3'd0, 64'd0, 2'd0);
    expect_wb("R1", 3'd4, 64'd0, 2'b00);
    for (int w = 0; w < 16; w++) begin
      issue(TS, 3'd1, 3'd0, 3'd0, 64'(w), 2'b01);
      issue(LD, 3'd2, 3'd1, 3'd0, 64'd0, 2'd0);
      chk("R1", "mem tag after reset", 64'(wb_tag), 64'd0);
    end
  endtask

  task automatic t_tagset_move();
    issue(TS, 3'd5, 3'd0, 3'd0, 64'hDEAD_0000_BEEF_0001, 2'b11);
    expect_wb("R10", 3'd5, 64'hDEAD_0000_BEEF_0001, 2'b11);
    issue(MV, 3'd6, 3'd5, 3'd0, 64'd0, 2'd0);
    expect_wb("R5", 3'd6, 64'hDEAD_0000_BEEF_0001, 2'b11);
    issue(7, 3'd6, 3'd0, 3'd0, 64'd5, 2'b01);
    chk("R10", "reserved op no write", 64'(wb_valid), 64'd0);
    issue(MV, 3'd7, 3'd6, 3'd0, 64'd0, 2'd0);
    expect_wb("R10", 3'd7, 64'hDEAD_0000_BEEF_0001, 2'b11);
  endtask

  task automatic t_store_load();
    for (int k = 0; k < 4; k++) begin
      issue(TS, 3'd1, 3'd0, 3'd0, 64'(8 + k), 2'b01);
      issue(TS, 3'd2, 3'd0, 3'd0, 64'hA5A5_0000_0000_0000 + 64'(k), 2'(k));
      issue(ST, 3'd0, 3'd1, 3'd2, 64'd0, 2'd0);
      chk("R4", "store wb_valid", 64'(wb_valid), 64'd0);
      chk("R4", "store fault", 64'(fault), 64'd0);
    end
    for (int k = 0; k < 4; k++) begin
      issue(TS, 3'd1, 3'd0, 3'd0, 64'(8 + k), 2'b01);
      issue(LD, 3'd3, 3'd1, 3'd0, 64'd0, 2'd0);
      expect_wb("R2", 3'd3, 64'hA5A5_0000_0000_0000 + 64'(k), 2'(k));
    end
    // upper base bits beyond the word index do not select a different word
    issue(TS, 3'd1, 3'd0, 3'd0, 64'hF000_0000_0000_0009, 2'b01);
    issue(LD, 3'd3, 3'd1, 3'd0, 64'd0, 2'd0);
    expect_wb("R2", 3'd3, 64'hA5A5_0000_0000_0001, 2'b01);
  endtask

  task automatic t_bad_base();
    issue(TS, 3'd1, 3'd0, 3'd0, 64'd3, 2'b01);
    issue(TS, 3'd2, 3'd0, 3'd0, 64'h1234_5678_9ABC_DEF0, 2'b10);
    issue(ST, 3'd0, 3'd1, 3'd2, 64'd0, 2'd0);
    issue(TS, 3'd4, 3'd0, 3'd0, 64'h77, 2'b00);
    for (int b = 0; b < 4; b++) begin
      if (b == 1) continue;
      issue(TS, 3'd1, 3'd0, 3'd0, 64'd3, 2'(b));
      issue(LD, 3'd4, 3'd1, 3'd0, 64'd0, 2'd0);
      expect_fault("R3", 2'b01);
      nop();
      chk("R9", "fault pulse ends", 64'(fault), 64'd0);
      chk("R9", "code idle", 64'(fault_code), 64'd0);
      issue(ST, 3'd0, 3'd1, 3'd5, 64'd0, 2'd0);
      expect_fault("R3", 2'b01);
    end
    issue(MV, 3'd7, 3'd4, 3'd0, 64'd0, 2'd0);
    expect_wb("R3", 3'd7, 64'h77, 2'b00);
    issue(TS, 3'd1, 3'd0, 3'd0, 64'd3, 2'b01);
    issue(LD, 3'd3, 3'd1, 3'd0, 64'd0, 2'd0);
    expect_wb("R3", 3'd3, 64'h1234_5678_9ABC_DEF0, 2'b10);
  endtask

  task automatic t_self_store();
    issue(TS, 3'd1, 3'd0, 3'd0, 64'd9, 2'b01);
    issue(ST, 3'd0, 3'd1, 3'd1, 64'd0, 2'd0);
    chk("R4", "self store no fault", 64'(fault), 64'd0);
    issue(LD, 3'd2, 3'd1, 3'd0, 64'd0, 2'd0);
    expect_wb("R4", 3'd2, 64'd9, 2'b01);
  endtask

  task automatic t_add();
    issue(TS, 3'd1, 3'd0, 3'd0, 64'd100, 2'b01);
    issue(TS, 3'd2, 3'd0, 3'd0, 64'd23, 2'b00);
    issue(AD, 3'd3, 3'd1, 3'd2, 64'd0, 2'd0);
    expect_wb("R6", 3'd3, 64'd123, 2'b00);
    issue(TS, 3'd2, 3'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b10);
    issue(AD, 3'd3, 3'd1, 3'd2, 64'd0, 2'd0);
    expect_wb("R6", 3'd3, 64'd99, 2'b00);
    issue(LD, 3'd4, 3'd3, 3'd0, 64'd0, 2'd0);
    expect_fault("R3", 2'b01);
  endtask

  task automatic t_branch();
    issue(TS, 3'd1, 3'd0, 3'd0, 64'h0000_4000_0000_1230, 2'b10);
    issue(JP, 3'd0, 3'd1, 3'd0, 64'd0, 2'd0);
    chk("R7", "br_valid", 64'(br_valid), 64'd1);
    chk("R7", "br_target", br_target, 64'h0000_4000_0000_1230);
    chk("R7", "no fault", 64'(fault), 64'd0);
    nop();
    chk("R7", "br pulse ends", 64'(br_valid), 64'd0);
    for (int b = 0; b < 4; b++) begin
      if (b == 2) continue;
      issue(TS, 3'd1, 3'd0, 3'd0, 64'h0000_4000_0000_1230, 2'(b));
      issue(JP, 3'd0, 3'd1, 3'd0, 64'd0, 2'd0);
      expect_fault("R8", 2'b10);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    nop();
    t_reset();
    t_tagset_move();
    t_store_load();
    t_bad_base();
    t_self_store();
    t_add();
    t_branch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule